// File: doc/BRIEF.md
# Return-Address Stack with Overflow Guard

This block holds the return addresses of a small microcontroller core. It sits apart from program and data memory and has 16 entries of 15 bits each. A call or an interrupt vector pushes the current program counter. A return pops it back, presenting the saved value on `ret_pc_o` in the same cycle as the pop request.

A 5-bit pointer always addresses the entry in use. Its reset value, 0x1F, means "empty". The fifth bit lets the block tell a push past the last entry from a pop of an empty stack. Software can move the pointer and then read or patch the addressed entry through a high byte and a low byte.

Overflow and underflow set sticky flags in either operating mode. A static configuration input selects the mode:
- **Circular mode:** the stack wraps, so the seventeenth push overwrites the first.
- **Fault mode:** every overflow or underflow also produces a one-cycle reset request to the core.

Top module: `ret_addr_stack`

## Requirements
- R1: After reset the pointer reads 0x1F, both flags and `rst_req_o` are 0, and every entry holds zero.
- R2: A push increments the pointer (modulo 32) and stores `push_pc_i` in entry `(pointer+1) mod 16`. From the next cycle the top-of-stack outputs show that value.
- R3: While a pop is requested, `ret_pc_o` shows the currently addressed top-of-stack value combinationally. At the clock edge the pointer decrements (modulo 32).
- R4: A push while the pointer is 0x0F sets the overflow flag. The pointer becomes 0x10, and entry 0 is overwritten, so the seventeenth consecutive push from empty replaces the first.
- R5: A pop while the pointer is 0x1F sets the underflow flag, and the pointer becomes 0x1E.
- R6: `rst_req_o` is high for exactly the one cycle after an overflow or underflow event, and only when `halt_on_err_i` is 1. With `halt_on_err_i` at 0 it stays low, while the flags are still set.
- R7: Flags are sticky. A flag write clears the overflow flag when bit 0 of `flag_wdata_i` is 0, and clears the underflow flag when bit 1 is 0. Writing 1 never sets a flag. An event in the same cycle as a clear leaves the flag set.
- R8: With the pointer at 0x1F, the top-of-stack value (`tos_*` and `ret_pc_o`) reads zero when `halt_on_err_i` is 1. It reads entry 15 when `halt_on_err_i` is 0.
- R9: A pointer write loads `ptr_wdata_i` into the pointer. The top-of-stack outputs then show entry `pointer mod 16`.
- R10: A high-byte write stores `tos_wdata_i[6:0]` into bits 14:8 of the addressed entry. A low-byte write stores `tos_wdata_i` into bits 7:0. Both use the pointer value before the edge. `tos_hi_o[7]` always reads 0.
- R11: When push and pop are requested in the same cycle, only the push is performed, and the pop has no effect.
- R12: Pointer writes and top-of-stack byte writes in a cycle that has a push or pop request are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| halt_on_err_i | input | 1 | 1 = fault mode (reset request on error), 0 = circular mode |
| push_i | input | 1 | Push request (call or interrupt) |
| push_pc_i | input | 15 | Program counter to push |
| pop_i | input | 1 | Pop request (return) |
| ret_pc_o | output | 15 | Return address, equal to the current top-of-stack value |
| ptr_wr_i | input | 1 | Software pointer write strobe |
| ptr_wdata_i | input | 5 | New pointer value |
| tos_hi_wr_i | input | 1 | Software high-byte write strobe |
| tos_lo_wr_i | input | 1 | Software low-byte write strobe |
| tos_wdata_i | input | 8 | Byte data for top-of-stack writes |
| flag_wr_i | input | 1 | Flag write strobe |
| flag_wdata_i | input | 2 | Flag write data: bit 0 overflow, bit 1 underflow (0 clears) |
| ptr_o | output | 5 | Current stack pointer |
| tos_hi_o | output | 8 | Top-of-stack bits 14:8, zero-extended |
| tos_lo_o | output | 8 | Top-of-stack bits 7:0 |
| ovf_o | output | 1 | Sticky overflow flag |
| unf_o | output | 1 | Sticky underflow flag |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
The assertions check the following on every cycle:
- the pointer steps on push, pop and software write;
- a pushed value shows up on the next cycle;
- flags get set and stay sticky;
- the reset request is tied to fault mode.

Some behaviours are only shown by the bench scenarios:
- the circular overwrite of entry 0 by the seventeenth push;
- the mode-dependent empty read;
- byte-level patching of entries;
- push winning over a simultaneous pop;
- software writes being dropped during hardware operations.

A reference model tracks all of these through long random mixes of operations in both modes.

// File: rtl/ras_pkg.sv
package ras_pkg;
    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2
    } ras_op_e;
endpackage

// File: rtl/ras_ptr_ctrl.sv
module ras_ptr_ctrl
    import ras_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int PTR_W = $clog2(DEPTH) + 1
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 push_i,
    input  logic                 pop_i,
    input  logic                 ptr_wr_i,
    input  logic [PTR_W-1:0]     ptr_wdata_i,
    output logic [PTR_W-1:0]     ptr_o,
    output logic [PTR_W-2:0]     push_idx_o,
    output ras_op_e              op_o,
    output logic                 ovf_evt_o,
    output logic                 unf_evt_o
);
    localparam int IDX_W = PTR_W - 1;
    localparam logic [PTR_W-1:0] EMPTY = '1;
    localparam logic [PTR_W-1:0] TOP   = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
    } state_t;

    state_t st_d, st_q;
    logic [PTR_W-1:0] inc_ptr;

    // push has priority; software write only in an idle cycle
    always_comb begin
        st_d      = st_q;
        op_o      = OP_IDLE;
        ovf_evt_o = 1'b0;
        unf_evt_o = 1'b0;
        inc_ptr   = st_q.ptr + 1'b1;
        if (push_i) begin
            op_o      = OP_PUSH;
            st_d.ptr  = inc_ptr;
            ovf_evt_o = (st_q.ptr == TOP);
        end else if (pop_i) begin
            op_o      = OP_POP;
            st_d.ptr  = st_q.ptr - 1'b1;
            unf_evt_o = (st_q.ptr == EMPTY);
        end else if (ptr_wr_i) begin
            st_d.ptr  = ptr_wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q.ptr <= EMPTY;
        else         st_q     <= st_d;
    end

    assign ptr_o      = st_q.ptr;
    assign push_idx_o = inc_ptr[IDX_W-1:0];

    assert_push_inc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        push_i |=> ptr_o == PTR_W'($past(ptr_o) + 1'b1));

    assert_pop_dec_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!push_i && pop_i) |=> ptr_o == PTR_W'($past(ptr_o) - 1'b1));

    assert_sw_ptr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!push_i && !pop_i && ptr_wr_i) |=> ptr_o == $past(ptr_wdata_i));
endmodule

// File: rtl/ras_store.sv
module ras_store #(
    parameter int DEPTH = 16,
    parameter int PC_W  = 15,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [PC_W-1:0]   wr_mask_i,
    input  logic [PC_W-1:0]   wr_data_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [PC_W-1:0]   rd_data_o
);
    logic [PC_W-1:0] ent_d [DEPTH];
    logic [PC_W-1:0] ent_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        always_comb begin
            ent_d[i] = ent_q[i];
            if (wr_en_i && (wr_idx_i == IDX_W'(i))) begin
                ent_d[i] = (ent_q[i] & ~wr_mask_i) | (wr_data_i & wr_mask_i);
            end
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) ent_q[i] <= '0;
            else         ent_q[i] <= ent_d[i];
        end
    end

    assign rd_data_o = ent_q[rd_idx_i];
endmodule

// File: rtl/ras_flags.sv
module ras_flags (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       halt_on_err_i,
    input  logic       ovf_evt_i,
    input  logic       unf_evt_i,
    input  logic       flag_wr_i,
    input  logic [1:0] flag_wdata_i,
    output logic       ovf_o,
    output logic       unf_o,
    output logic       rst_req_o
);
    typedef struct packed {
        logic ovf;
        logic unf;
        logic req;
    } flag_t;

    flag_t fl_d, fl_q;

    // events win over a clear in the same cycle
    always_comb begin
        fl_d     = fl_q;
        if (flag_wr_i && !flag_wdata_i[0]) fl_d.ovf = 1'b0;
        if (flag_wr_i && !flag_wdata_i[1]) fl_d.unf = 1'b0;
        if (ovf_evt_i) fl_d.ovf = 1'b1;
        if (unf_evt_i) fl_d.unf = 1'b1;
        fl_d.req = halt_on_err_i & (ovf_evt_i | unf_evt_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) fl_q <= '0;
        else         fl_q <= fl_d;
    end

    assign ovf_o     = fl_q.ovf;
    assign unf_o     = fl_q.unf;
    assign rst_req_o = fl_q.req;

    assert_ovf_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_evt_i |=> ovf_o);

    assert_unf_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        unf_evt_i |=> unf_o);

    assert_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ovf_o && !(flag_wr_i && !flag_wdata_i[0])) |=> ovf_o);

    assert_req_mode_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!halt_on_err_i && !rst_req_o) |=> !rst_req_o || $past(halt_on_err_i));
endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
    import ras_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int PC_W  = 15,
    parameter int PTR_W = $clog2(DEPTH) + 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              halt_on_err_i,
    input  logic              push_i,
    input  logic [PC_W-1:0]   push_pc_i,
    input  logic              pop_i,
    output logic [PC_W-1:0]   ret_pc_o,
    input  logic              ptr_wr_i,
    input  logic [PTR_W-1:0]  ptr_wdata_i,
    input  logic              tos_hi_wr_i,
    input  logic              tos_lo_wr_i,
    input  logic [7:0]        tos_wdata_i,
    input  logic              flag_wr_i,
    input  logic [1:0]        flag_wdata_i,
    output logic [PTR_W-1:0]  ptr_o,
    output logic [7:0]        tos_hi_o,
    output logic [7:0]        tos_lo_o,
    output logic              ovf_o,
    output logic              unf_o,
    output logic              rst_req_o
);
    localparam int IDX_W = PTR_W - 1;
    localparam int HI_W  = PC_W - 8;
    localparam logic [PTR_W-1:0] EMPTY = '1;

    ras_op_e          op;
    logic [IDX_W-1:0] push_idx;
    logic             ovf_evt, unf_evt;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [PC_W-1:0]  wr_mask, wr_data, rd_data, tos;
    logic [PC_W-1:0]  sw_data;

    ras_ptr_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_ptr (
        .clk_i(clk_i), .rst_ni(rst_ni), .push_i(push_i), .pop_i(pop_i),
        .ptr_wr_i(ptr_wr_i), .ptr_wdata_i(ptr_wdata_i), .ptr_o(ptr_o),
        .push_idx_o(push_idx), .op_o(op), .ovf_evt_o(ovf_evt), .unf_evt_o(unf_evt)
    );

    assign sw_data = {tos_wdata_i[HI_W-1:0], tos_wdata_i};

    always_comb begin
        wr_en   = 1'b0;
        wr_idx  = ptr_o[IDX_W-1:0];
        wr_mask = '0;
        wr_data = sw_data;
        case (op)
            OP_PUSH: begin
                wr_en   = 1'b1;
                wr_idx  = push_idx;
                wr_mask = '1;
                wr_data = push_pc_i;
            end
            OP_IDLE: begin
                if (tos_hi_wr_i) wr_mask[PC_W-1:8] = '1;
                if (tos_lo_wr_i) wr_mask[7:0]      = '1;
                wr_en = tos_hi_wr_i | tos_lo_wr_i;
            end
            default: ;
        endcase
    end

    ras_store #(.DEPTH(DEPTH), .PC_W(PC_W), .IDX_W(IDX_W)) u_store (
        .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
        .wr_mask_i(wr_mask), .wr_data_i(wr_data),
        .rd_idx_i(ptr_o[IDX_W-1:0]), .rd_data_o(rd_data)
    );

    ras_flags u_flags (
        .clk_i(clk_i), .rst_ni(rst_ni), .halt_on_err_i(halt_on_err_i),
        .ovf_evt_i(ovf_evt), .unf_evt_i(unf_evt),
        .flag_wr_i(flag_wr_i), .flag_wdata_i(flag_wdata_i),
        .ovf_o(ovf_o), .unf_o(unf_o), .rst_req_o(rst_req_o)
    );

    // empty view depends on mode
    assign tos      = (halt_on_err_i && (ptr_o == EMPTY)) ? '0 : rd_data;
    assign ret_pc_o = tos;
    assign tos_lo_o = tos[7:0];
    assign tos_hi_o = {{(16 - PC_W){1'b0}}, tos[PC_W-1:8]};

    assert_push_stored_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (push_i && !(halt_on_err_i && PTR_W'(ptr_o + 1'b1) == EMPTY))
        |=> ret_pc_o == $past(push_pc_i));
endmodule

// File: tb/tb_ret_addr_stack.sv
module tb_ret_addr_stack;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        mode, push, pop, ptr_wr, hi_wr, lo_wr, fwr;
    logic [14:0] pc;
    logic [4:0]  ptr_wd;
    logic [7:0]  twd;
    logic [1:0]  fwd;
    logic [14:0] ret_pc;
    logic [4:0]  ptr;
    logic [7:0]  tos_hi, tos_lo;
    logic        ovf, unf, rq;

    int n_chk = 0;
    int n_bad = 0;

    logic [14:0] m_mem [16];
    logic [4:0]  m_ptr;
    logic        m_ovf, m_unf, m_rq;

    always #5 clk = ~clk;

    ret_addr_stack dut (
        .clk_i(clk), .rst_ni(rst_n), .halt_on_err_i(mode),
        .push_i(push), .push_pc_i(pc), .pop_i(pop), .ret_pc_o(ret_pc),
        .ptr_wr_i(ptr_wr), .ptr_wdata_i(ptr_wd),
        .tos_hi_wr_i(hi_wr), .tos_lo_wr_i(lo_wr), .tos_wdata_i(twd),
        .flag_wr_i(fwr), .flag_wdata_i(fwd),
        .ptr_o(ptr), .tos_hi_o(tos_hi), .tos_lo_o(tos_lo),
        .ovf_o(ovf), .unf_o(unf), .rst_req_o(rq)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [14:0] exp_tos();
        return (mode && m_ptr == 5'h1F) ? 15'h0 : m_mem[m_ptr[3:0]];
    endfunction

    task automatic clr_in();
        push = 0; pop = 0; ptr_wr = 0; hi_wr = 0; lo_wr = 0; fwr = 0;
        pc = '0; ptr_wd = '0; twd = '0; fwd = '0;
    endtask

    task automatic model_upd();
        logic ev_o, ev_u;
        ev_o = push && m_ptr == 5'h0F;
        ev_u = !push && pop && m_ptr == 5'h1F;
        if (push) begin
            m_ptr = m_ptr + 5'd1;
            m_mem[m_ptr[3:0]] = pc;
        end else if (pop) begin
            m_ptr = m_ptr - 5'd1;
        end else begin
            if (hi_wr) m_mem[m_ptr[3:0]][14:8] = twd[6:0];
            if (lo_wr) m_mem[m_ptr[3:0]][7:0]  = twd;
            if (ptr_wr) m_ptr = ptr_wd;
        end
        if (fwr && !fwd[0]) m_ovf = 0;
        if (fwr && !fwd[1]) m_unf = 0;
        if (ev_o) m_ovf = 1;
        if (ev_u) m_unf = 1;
        m_rq = mode && (ev_o || ev_u);
    endtask

    // inputs set at negedge; check comb return, clock, compare state
    task automatic step(input string tag);
        logic [14:0] t;
        #1;
        if (pop && !push) chk(tag, {1'b0, ret_pc}, {1'b0, exp_tos()});
        model_upd();
        @(posedge clk);
        #1;
        t = exp_tos();
        chk(tag, {11'd0, ptr}, {11'd0, m_ptr});
        chk(tag, {8'd0, tos_hi}, {9'd0, t[14:8]});
        chk(tag, {8'd0, tos_lo}, {8'd0, t[7:0]});
        chk(tag, {13'd0, ovf, unf, rq}, {13'd0, m_ovf, m_unf, m_rq});
        @(negedge clk);
        clr_in();
    endtask

    task automatic do_reset(input logic m);
        mode = m;
        clr_in();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        for (int i = 0; i < 16; i++) m_mem[i] = '0;
        m_ptr = 5'h1F; m_ovf = 0; m_unf = 0; m_rq = 0;
        chk("R1", {11'd0, ptr}, 16'h001F);
        chk("R1", {13'd0, ovf, unf, rq}, 16'h0);
        chk("R1", {tos_hi, tos_lo}, 16'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0A17));
        rst_n = 0;
        mode  = 0;
        clr_in();
        @(negedge clk);

        // circular mode
        do_reset(1'b0);
        for (int i = 0; i < 16; i++) begin
            push = 1; pc = 15'h100 + 15'(i); step("R2");
        end
        chk("R2", {11'd0, ptr}, 16'h000F);
        chk("R2", {tos_hi, tos_lo}, 16'h010F);
        push = 1; pc = 15'h7ABC; step("R4");
        chk("R4", {11'd0, ptr}, 16'h0010);
        chk("R4", {tos_hi, tos_lo}, 16'h7ABC);
        chk("R4", {15'd0, ovf}, 16'h1);
        chk("R6", {15'd0, rq}, 16'h0);
        fwr = 1; fwd = 2'b11; step("R7");
        chk("R7", {15'd0, ovf}, 16'h1);
        fwr = 1; fwd = 2'b10; step("R7");
        chk("R7", {15'd0, ovf}, 16'h0);
        pop = 1; #1 chk("R3", {1'b0, ret_pc}, 16'h7ABC);
        step("R3");
        chk("R3", {11'd0, ptr}, 16'h000F);
        push = 1; pop = 1; pc = 15'h1234; step("R11");
        chk("R11", {11'd0, ptr}, 16'h0010);
        chk("R11", {tos_hi, tos_lo}, 16'h1234);
        push = 1; pc = 15'h0555; ptr_wr = 1; ptr_wd = 5'h03; lo_wr = 1; twd = 8'hEE; step("R12");
        chk("R12", {11'd0, ptr}, 16'h0011);
        chk("R12", {tos_hi, tos_lo}, 16'h0555);
        ptr_wr = 1; ptr_wd = 5'h0F; step("R9");
        chk("R9", {tos_hi, tos_lo}, 16'h010F);
        hi_wr = 1; twd = 8'hFF; step("R10");
        lo_wr = 1; twd = 8'h5A; step("R10");
        chk("R10", {tos_hi, tos_lo}, 16'h7F5A);
        ptr_wr = 1; ptr_wd = 5'h1F; step("R8");
        chk("R8", {tos_hi, tos_lo}, 16'h7F5A);

        // fault mode
        do_reset(1'b1);
        chk("R8", {1'b0, ret_pc}, 16'h0);
        pop = 1; step("R5");
        chk("R5", {11'd0, ptr}, 16'h001E);
        chk("R5", {15'd0, unf}, 16'h1);
        chk("R6", {15'd0, rq}, 16'h1);
        fwr = 1; fwd = 2'b01; step("R6");
        chk("R6", {15'd0, rq}, 16'h0);
        chk("R7", {15'd0, unf}, 16'h0);
        ptr_wr = 1; ptr_wd = 5'h0F; step("R9");
        push = 1; pc = 15'h0042; fwr = 1; fwd = 2'b00; step("R7");
        chk("R6", {15'd0, rq}, 16'h1);
        chk("R7", {15'd0, ovf}, 16'h1);

        // random mix in both modes
        for (int m = 0; m < 2; m++) begin
            do_reset(m[0]);
            for (int n = 0; n < 3000; n++) begin
                int r;
                r = int'($urandom % 16);
                if (r < 5) begin
                    push = 1; pc = 15'($urandom); step("R2");
                end else if (r < 10) begin
                    pop = 1; step("R3");
                end else if (r == 10) begin
                    push = 1; pop = 1; pc = 15'($urandom); step("R11");
                end else if (r == 11) begin
                    ptr_wr = 1; ptr_wd = 5'($urandom); step("R9");
                end else if (r == 12) begin
                    hi_wr = 1'($urandom); lo_wr = 1'($urandom); twd = 8'($urandom);
                    pop = (($urandom % 4) == 0); step("R10");
                end else if (r == 13) begin
                    fwr = 1; fwd = 2'($urandom); step("R7");
                end else begin
                    step("R12");
                end
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule